// File: doc/BRIEF.md
# Multichannel ADC Scan Controller

This block sits between a simple register bus and a 16-channel sampling converter. Software programs a last-channel number, a gain code and a trigger mode through byte offsets on the bus. The block then issues conversion requests to the converter over a start/done handshake, one at a time. Each request carries the channel number and the gain code. A request comes from a software strobe, a pacer tick or an external trigger pulse. With auto-scan enabled, successive conversions walk from channel 0 up to the programmed last channel and wrap. With auto-scan disabled, every conversion uses that one channel.

Each result the converter returns is placed in a deep sample FIFO, which software drains through the data offset. The status register reports busy, empty, half-full and full, and the full and half-full flags read low when active. The FIFO is cleared by holding its enable bit high, so writing 0, then 1, then 0 empties it. An interrupt line collects one conversion-side source and one trigger-side source, chosen by an interrupt control register. The line stays high until software writes the clear offset. A DAC word register and a 16-bit digital in/out port complete the map.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset, status (0x08) reads 0x0060: busy 0, full_n 1, half_n 1, data-available 0, gain 0. Trigger control (0x0A) reads 0x0000, and `irq` and `conv_start` are 0.
- R2: A write to 0x08 with bits 2:0 in 0..4 stores that gain code. Codes 5..7 leave the stored code unchanged. The code reads back in status bits 2:0 and is driven on `conv_range` with each conversion.
- R3: A write of any value to 0x0E makes `conv_start` high for exactly one cycle, the cycle after the write. Status bit 7 (busy) then reads 1 until the cycle after `conv_done`.
- R4: A conversion request that arrives while busy is ignored, and `conv_start` stays 0. Once the conversion completes, a new request is accepted.
- R5: Trigger control bits are bit 0 auto-scan, bit 1 pacer enable and bit 2 external enable, read back in bits 2:0. A `pacer_tick` starts a conversion only when bit 1 is set, and an `ext_trig` pulse only when bit 2 is set.
- R6: With auto-scan on, conversions use channels 0, 1, … up to the channel register (0x06) value, then wrap to 0. A write to 0x06 or 0x0A restarts the walk at channel 0.
- R7: With auto-scan off, every conversion uses the channel register value.
- R8: `conv_data` is stored in the FIFO when `conv_done` is high while busy. A read of 0x00 returns the oldest sample and removes it. A read of an empty FIFO returns 0. Status bit 4 reads 1 whenever at least one sample is held.
- R9: Status bit 5 reads 0 when the FIFO holds at least half its depth (512). Bit 6 reads 0 when it holds its full depth (1024). A sample that arrives while the FIFO is full is dropped.
- R10: While interrupt control (0x0C) bit 2 is 1, the FIFO is held empty and incoming samples are dropped. The sequence 0, 1, 0 therefore clears it.
- R11: Interrupt control bits 3:0 read back in trigger control bits 7:4.
- R12: With 0x0C bit 0 = 0, each stored sample sets the interrupt. With bit 0 = 1, the FIFO reaching half depth sets it. With bit 3 = 1, a `pacer_tick` (bit 1 = 0) or an `ext_trig` pulse (bit 1 = 1) also sets it. With bit 3 = 0, those pulses do not. `irq` stays high once set.
- R13: A write of any value to 0x48 drops `irq` in the next cycle. An interrupt event in the same cycle as that write wins, and `irq` stays 1.
- R14: A write to 0x00 sets `dac_out`. A write to 0x02 sets `dout`, and a read of 0x02 returns `din`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the FIFO at 0x00) |
| bus_addr | input | 7 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register (combinational) |
| pacer_tick | input | 1 | Pacer timer pulse |
| ext_trig | input | 1 | External trigger pulse |
| conv_start | output | 1 | One-cycle conversion request to the converter |
| conv_chan | output | 4 | Channel for the current conversion |
| conv_range | output | 3 | Gain code for the current conversion |
| conv_done | input | 1 | Converter reports a result |
| conv_data | input | 16 | Converter result |
| irq | output | 1 | Interrupt line, held until cleared |
| dac_out | output | 16 | DAC word register |
| dout | output | 16 | Digital output register |
| din | input | 16 | Digital input port |

## Verification
A wrong scan index shows up in the very next `conv_start` cycle as an unexpected `conv_chan`. It also shows up in the FIFO contents, where the bench tags each sample with the channel and gain code it was taken with. A wrong FIFO count or pointer appears as a misordered or missing word when the FIFO is drained. It also appears as a half-full or full flag that flips one sample early or late. Those flags are probed at exactly 511, 512, 1024 and 1025 conversions. A stuck busy state or a wrong interrupt-source select shows up within one cycle, on `conv_start` or on `irq`.

// File: rtl/adcs_pkg.sv
package adcs_pkg;

    localparam int ADDR_W      = 7;
    localparam int DATA_W      = 16;
    localparam int CHAN_W      = 4;
    localparam int RANGE_W     = 3;
    localparam int RANGE_CODES = 5;

    localparam logic [ADDR_W-1:0] OFS_DATA  = 7'h00;
    localparam logic [ADDR_W-1:0] OFS_DIO   = 7'h02;
    localparam logic [ADDR_W-1:0] OFS_CHAN  = 7'h06;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 7'h08;
    localparam logic [ADDR_W-1:0] OFS_TRIG  = 7'h0A;
    localparam logic [ADDR_W-1:0] OFS_INTC  = 7'h0C;
    localparam logic [ADDR_W-1:0] OFS_SOFT  = 7'h0E;
    localparam logic [ADDR_W-1:0] OFS_ICLR  = 7'h48;

    // trigger control, bits 2:0
    typedef struct packed {
        logic ext_sel;
        logic pacer_sel;
        logic scan_en;
    } trig_cfg_t;

    // interrupt control, bits 3:0
    typedef struct packed {
        logic src1_en;
        logic fifo_hold;
        logic src1_ext;
        logic src0_half;
    } int_cfg_t;

    // status register low byte
    typedef struct packed {
        logic               busy;
        logic               full_n;
        logic               half_n;
        logic               avail;
        logic               rsvd;
        logic [RANGE_W-1:0] range;
    } stat_t;

    typedef enum logic {CV_IDLE, CV_BUSY} cv_state_t;

    function automatic logic range_ok(input logic [RANGE_W-1:0] code);
        return code < RANGE_W'(RANGE_CODES);
    endfunction

    function automatic logic [CHAN_W-1:0] next_chan(input logic [CHAN_W-1:0] idx,
                                                    input logic [CHAN_W-1:0] last);
        return (idx >= last) ? '0 : idx + 1'b1;
    endfunction

endpackage

// File: rtl/adcs_fifo.sv
module adcs_fifo
    import adcs_pkg::*;
#(
    parameter int DEPTH = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic              half,
    output logic              full,
    output logic              half_cross
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_C = CW'(DEPTH / 2);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wp, rp;
    logic [CW-1:0]     cnt;
    logic              push_ok, pop_ok;

    assign empty   = (cnt == '0);
    assign full    = (cnt == FULL_C);
    assign half    = (cnt >= HALF_C);
    assign push_ok = push && !full && !flush;
    assign pop_ok  = pop && !empty && !flush;
    assign half_cross = push_ok && !pop_ok && (cnt == HALF_C - 1'b1);
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push_ok) wp <= wp + 1'b1;
            if (pop_ok)  rp <= rp + 1'b1;
            cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= wdata;
    end

    assert_count_bound_R9: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL_C);
    assert_full_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (full && !pop && !flush) |=> full);
    assert_flush_empty_R10: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty);

endmodule

// File: rtl/adcs_seq.sv
module adcs_seq
    import adcs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  trig_cfg_t          trig,
    input  logic [CHAN_W-1:0]  last_chan,
    input  logic [RANGE_W-1:0] range_code,
    input  logic               soft_req,
    input  logic               restart,
    input  logic               pacer_tick,
    input  logic               ext_trig,
    input  logic               conv_done,
    input  logic [DATA_W-1:0]  conv_data,
    output logic               conv_start,
    output logic [CHAN_W-1:0]  conv_chan,
    output logic [RANGE_W-1:0] conv_range,
    output logic               busy,
    output logic               push,
    output logic [DATA_W-1:0]  push_data
);
    cv_state_t         state;
    logic [CHAN_W-1:0] idx;
    logic              req, start;

    assign req   = soft_req || (trig.pacer_sel && pacer_tick) || (trig.ext_sel && ext_trig);
    assign start = req && (state == CV_IDLE);
    assign busy  = (state == CV_BUSY);
    assign push  = busy && conv_done;
    assign push_data = conv_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= CV_IDLE;
            idx        <= '0;
            conv_start <= 1'b0;
            conv_chan  <= '0;
            conv_range <= '0;
        end else begin
            conv_start <= start;
            if (start) begin
                conv_chan  <= trig.scan_en ? idx : last_chan;
                conv_range <= range_code;
                state      <= CV_BUSY;
            end else if (push) begin
                state      <= CV_IDLE;
            end
            if (restart)
                idx <= '0;
            else if (start && trig.scan_en)
                idx <= next_chan(idx, last_chan);
        end
    end

    assert_ignore_busy_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && !conv_done) |=> !conv_start);
    assert_done_frees_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && conv_done) |=> !busy);

endmodule

// File: rtl/adcs_regs.sv
module adcs_regs
    import adcs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [DATA_W-1:0]  fifo_head,
    input  logic               fifo_empty,
    input  logic               fifo_half,
    input  logic               fifo_full,
    input  logic               busy,
    input  logic [DATA_W-1:0]  din,
    output logic [CHAN_W-1:0]  last_chan,
    output logic [RANGE_W-1:0] range_code,
    output trig_cfg_t          trig,
    output int_cfg_t           intc,
    output logic [DATA_W-1:0]  dac_out,
    output logic [DATA_W-1:0]  dout,
    output logic               soft_req,
    output logic               iclr,
    output logic               restart,
    output logic               pop
);
    stat_t stat;

    assign soft_req = bus_wr && (bus_addr == OFS_SOFT);
    assign iclr     = bus_wr && (bus_addr == OFS_ICLR);
    assign restart  = bus_wr && ((bus_addr == OFS_CHAN) || (bus_addr == OFS_TRIG));
    assign pop      = bus_rd && (bus_addr == OFS_DATA) && !fifo_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_chan  <= '0;
            range_code <= '0;
            trig       <= '0;
            intc       <= '0;
            dac_out    <= '0;
            dout       <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_DATA: dac_out <= bus_wdata;
                OFS_DIO:  dout    <= bus_wdata;
                OFS_CHAN: last_chan <= bus_wdata[CHAN_W-1:0];
                OFS_STAT: if (range_ok(bus_wdata[RANGE_W-1:0]))
                              range_code <= bus_wdata[RANGE_W-1:0];
                OFS_TRIG: trig <= trig_cfg_t'(bus_wdata[2:0]);
                OFS_INTC: intc <= int_cfg_t'(bus_wdata[3:0]);
                default: ;
            endcase
        end
    end

    always_comb begin
        stat.busy   = busy;
        stat.full_n = !fifo_full;
        stat.half_n = !fifo_half;
        stat.avail  = !fifo_empty;
        stat.rsvd   = 1'b0;
        stat.range  = range_code;
        case (bus_addr)
            OFS_DATA: bus_rdata = fifo_empty ? '0 : fifo_head;
            OFS_DIO:  bus_rdata = din;
            OFS_CHAN: bus_rdata = DATA_W'(last_chan);
            OFS_STAT: bus_rdata = DATA_W'(stat);
            OFS_TRIG: bus_rdata = DATA_W'({intc, 1'b0, trig});
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/adcs_irq.sv
module adcs_irq
    import adcs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  int_cfg_t intc,
    input  logic     push,
    input  logic     half_cross,
    input  logic     pacer_tick,
    input  logic     ext_trig,
    input  logic     clr,
    output logic     irq
);
    logic ev0, ev1, ev;

    assign ev0 = intc.src0_half ? half_cross : push;
    assign ev1 = intc.src1_en && (intc.src1_ext ? ext_trig : pacer_tick);
    assign ev  = ev0 || ev1;

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= ev || (irq && !clr);
    end

    assert_event_sets_R12: assert property (@(posedge clk) disable iff (rst)
        ev |=> irq);
    assert_clear_drops_R13: assert property (@(posedge clk) disable iff (rst)
        (clr && !ev) |=> !irq);

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
    import adcs_pkg::*;
#(
    parameter int FIFO_DEPTH = 1024
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               pacer_tick,
    input  logic               ext_trig,
    output logic               conv_start,
    output logic [CHAN_W-1:0]  conv_chan,
    output logic [RANGE_W-1:0] conv_range,
    input  logic               conv_done,
    input  logic [DATA_W-1:0]  conv_data,
    output logic               irq,
    output logic [DATA_W-1:0]  dac_out,
    output logic [DATA_W-1:0]  dout,
    input  logic [DATA_W-1:0]  din
);
    logic [CHAN_W-1:0]  last_chan;
    logic [RANGE_W-1:0] range_code;
    trig_cfg_t          trig;
    int_cfg_t           intc;
    logic               soft_req, iclr, restart, pop, busy, push;
    logic [DATA_W-1:0]  push_data, fifo_head;
    logic               fifo_empty, fifo_half, fifo_full, half_cross;

    adcs_regs u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fifo_head(fifo_head), .fifo_empty(fifo_empty), .fifo_half(fifo_half),
        .fifo_full(fifo_full), .busy(busy), .din(din),
        .last_chan(last_chan), .range_code(range_code), .trig(trig), .intc(intc),
        .dac_out(dac_out), .dout(dout), .soft_req(soft_req), .iclr(iclr),
        .restart(restart), .pop(pop)
    );

    adcs_seq u_seq (
        .clk(clk), .rst(rst), .trig(trig), .last_chan(last_chan),
        .range_code(range_code), .soft_req(soft_req), .restart(restart),
        .pacer_tick(pacer_tick), .ext_trig(ext_trig), .conv_done(conv_done),
        .conv_data(conv_data), .conv_start(conv_start), .conv_chan(conv_chan),
        .conv_range(conv_range), .busy(busy), .push(push), .push_data(push_data)
    );

    adcs_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .flush(intc.fifo_hold), .push(push),
        .wdata(push_data), .pop(pop), .head(fifo_head), .empty(fifo_empty),
        .half(fifo_half), .full(fifo_full), .half_cross(half_cross)
    );

    adcs_irq u_irq (
        .clk(clk), .rst(rst), .intc(intc), .push(push), .half_cross(half_cross),
        .pacer_tick(pacer_tick), .ext_trig(ext_trig), .clr(iclr), .irq(irq)
    );

endmodule

// File: tb/sim_adc_scan_ctrl.sv
module sim_adc_scan_ctrl;
    localparam logic [6:0] A_DATA = 7'h00, A_DIO = 7'h02, A_CHAN = 7'h06,
                           A_STAT = 7'h08, A_TRIG = 7'h0A, A_INTC = 7'h0C,
                           A_SOFT = 7'h0E, A_ICLR = 7'h48;

    logic        clk = 0, rst = 1;
    logic        bus_wr = 0, bus_rd = 0;
    logic [6:0]  bus_addr = 0;
    logic [15:0] bus_wdata = 0, bus_rdata;
    logic        pacer_tick = 0, ext_trig = 0;
    logic        conv_start, conv_done = 0, irq;
    logic [3:0]  conv_chan;
    logic [2:0]  conv_range;
    logic [15:0] conv_data = 0, dac_out, dout, din = 0;

    int n_chk = 0, n_fail = 0;
    bit auto_conv = 0, data_mode = 0, finished = 0;
    logic [15:0] seq_cnt = 0;

    always #5 clk = ~clk;

    adc_scan_ctrl u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pacer_tick(pacer_tick),
        .ext_trig(ext_trig), .conv_start(conv_start), .conv_chan(conv_chan),
        .conv_range(conv_range), .conv_done(conv_done), .conv_data(conv_data),
        .irq(irq), .dac_out(dac_out), .dout(dout), .din(din)
    );

    // converter model: answers one cycle after each start
    always @(negedge clk) begin
        if (auto_conv) begin
            conv_done = conv_start;
            if (conv_start) begin
                conv_data = data_mode ? seq_cnt : {conv_chan, 9'b0, conv_range};
                seq_cnt = seq_cnt + 1;
            end
        end
    end

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic bus_read(input logic [6:0] a, output logic [15:0] d);
        @(negedge clk); bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 0;
    endtask

    task automatic pulse_pacer;
        @(negedge clk); pacer_tick = 1;
        @(negedge clk); pacer_tick = 0;
    endtask

    task automatic pulse_ext;
        @(negedge clk); ext_trig = 1;
        @(negedge clk); ext_trig = 0;
    endtask

    task automatic manual_done(input logic [15:0] d);
        @(negedge clk); conv_done = 1; conv_data = d;
        @(negedge clk); conv_done = 0;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        bus_read(A_STAT, v); check("R1", "status", v, 16'h0060);
        bus_read(A_TRIG, v); check("R1", "trig ctrl", v, 16'h0000);
        check("R1", "irq", 16'(irq), 16'h0);
        check("R1", "conv_start", 16'(conv_start), 16'h0);
    endtask

    task automatic t_range;
        logic [15:0] v;
        bus_write(A_STAT, 16'h0003);
        bus_read(A_STAT, v); check("R2", "gain 3 stored", v & 16'h7, 16'h3);
        bus_write(A_STAT, 16'h0006);
        bus_read(A_STAT, v); check("R2", "gain 6 ignored", v & 16'h7, 16'h3);
    endtask

    task automatic t_soft;
        logic [15:0] v;
        bus_write(A_CHAN, 16'h0005);
        bus_write(A_SOFT, 16'h00FF);
        check("R3", "start after soft write", 16'(conv_start), 16'h1);
        check("R7", "single channel", 16'(conv_chan), 16'h5);
        check("R2", "conv_range", 16'(conv_range), 16'h3);
        @(negedge clk);
        check("R3", "start one cycle", 16'(conv_start), 16'h0);
        bus_read(A_STAT, v); check("R3", "busy set", v & 16'h80, 16'h80);
        bus_write(A_SOFT, 16'h0000);
        check("R4", "request while busy", 16'(conv_start), 16'h0);
        manual_done(16'h1234);
        bus_read(A_STAT, v); check("R8", "status after done", v, 16'h0073);
        check("R12", "eoc irq", 16'(irq), 16'h1);
        bus_read(A_DATA, v); check("R8", "fifo read", v, 16'h1234);
        bus_read(A_STAT, v); check("R8", "empty after pop", v, 16'h0063);
        bus_read(A_DATA, v); check("R8", "empty read", v, 16'h0000);
        bus_write(A_ICLR, 16'h0);
        check("R13", "irq cleared", 16'(irq), 16'h0);
        bus_write(A_SOFT, 16'h0);
        check("R4", "accepted after done", 16'(conv_start), 16'h1);
        manual_done(16'h0);
        bus_read(A_DATA, v);
        bus_write(A_ICLR, 16'h0);
    endtask

    task automatic t_ignored;
        pulse_pacer; check("R5", "pacer ignored", 16'(conv_start), 16'h0);
        pulse_ext;   check("R5", "ext ignored", 16'(conv_start), 16'h0);
    endtask

    task automatic t_scan;
        logic [15:0] v;
        logic [3:0] exp_ch [5] = '{0, 1, 2, 0, 1};
        bus_write(A_CHAN, 16'h0002);
        bus_write(A_TRIG, 16'h0003);
        bus_read(A_TRIG, v); check("R5", "trig readback", v, 16'h0003);
        auto_conv = 1; data_mode = 0;
        for (int i = 0; i < 5; i++) begin pulse_pacer; @(negedge clk); end
        for (int i = 0; i < 5; i++) begin
            bus_read(A_DATA, v);
            check("R6", "pacer scan sample", v, {exp_ch[i], 9'b0, 3'd3});
        end
        bus_write(A_TRIG, 16'h0005);
        bus_write(A_CHAN, 16'h0003);
        pulse_ext; @(negedge clk);
        pulse_ext; @(negedge clk);
        bus_write(A_TRIG, 16'h0005);
        pulse_ext; @(negedge clk);
        bus_read(A_DATA, v); check("R6", "ext scan ch0", v, 16'h0003);
        bus_read(A_DATA, v); check("R6", "ext scan ch1", v, 16'h1003);
        bus_read(A_DATA, v); check("R6", "restart ch0", v, 16'h0003);
        pulse_pacer; @(negedge clk);
        bus_read(A_STAT, v); check("R5", "pacer ignored in ext mode", v & 16'h10, 16'h0);
        bus_write(A_TRIG, 16'h0002);
        pulse_pacer; @(negedge clk);
        pulse_pacer; @(negedge clk);
        bus_read(A_DATA, v); check("R7", "fixed channel a", v, 16'h3003);
        bus_read(A_DATA, v); check("R7", "fixed channel b", v, 16'h3003);
        bus_write(A_TRIG, 16'h0000);
        bus_write(A_ICLR, 16'h0);
    endtask

    task automatic t_intsrc;
        logic [15:0] v;
        bus_write(A_INTC, 16'h000A);
        bus_read(A_TRIG, v); check("R11", "int bits readback", v, 16'h00A0);
        bus_write(A_ICLR, 16'h0);
        pulse_ext;   check("R12", "ext source", 16'(irq), 16'h1);
        bus_write(A_INTC, 16'h0008);
        bus_write(A_ICLR, 16'h0);
        pulse_ext;   check("R12", "ext not selected", 16'(irq), 16'h0);
        pulse_pacer; check("R12", "pacer source", 16'(irq), 16'h1);
        bus_write(A_ICLR, 16'h0);
        @(negedge clk); bus_wr = 1; bus_addr = A_ICLR; pacer_tick = 1;
        @(negedge clk); bus_wr = 0; pacer_tick = 0;
        check("R13", "event beats clear", 16'(irq), 16'h1);
        bus_write(A_ICLR, 16'h0);
        check("R13", "clear", 16'(irq), 16'h0);
        bus_write(A_INTC, 16'h0000);
        pulse_pacer; check("R12", "source 1 disabled", 16'(irq), 16'h0);
    endtask

    task automatic t_flush;
        logic [15:0] v;
        auto_conv = 1; data_mode = 0;
        bus_write(A_SOFT, 16'h0); @(negedge clk);
        bus_write(A_SOFT, 16'h0); @(negedge clk);
        bus_read(A_STAT, v); check("R8", "samples held", v & 16'h10, 16'h10);
        bus_write(A_INTC, 16'h0004);
        bus_read(A_STAT, v); check("R10", "hold empties", v & 16'h10, 16'h0);
        bus_write(A_SOFT, 16'h0); @(negedge clk);
        bus_read(A_STAT, v); check("R10", "dropped while held", v & 16'h10, 16'h0);
        bus_write(A_INTC, 16'h0000);
        bus_read(A_STAT, v); check("R10", "stays empty", v & 16'h10, 16'h0);
        bus_write(A_SOFT, 16'h0); @(negedge clk);
        bus_read(A_STAT, v); check("R10", "stores after release", v & 16'h10, 16'h10);
        bus_read(A_DATA, v);
        bus_write(A_ICLR, 16'h0);
    endtask

    task automatic t_fill;
        logic [15:0] v;
        int bad;
        bus_write(A_INTC, 16'h0004);
        bus_write(A_INTC, 16'h0001);
        bus_write(A_ICLR, 16'h0);
        bus_write(A_TRIG, 16'h0002);
        auto_conv = 1; data_mode = 1; seq_cnt = 0;
        for (int i = 0; i < 511; i++) begin pulse_pacer; @(negedge clk); end
        bus_read(A_STAT, v); check("R9", "511 not half", v & 16'h20, 16'h20);
        check("R12", "no half irq yet", 16'(irq), 16'h0);
        pulse_pacer; @(negedge clk);
        bus_read(A_STAT, v); check("R9", "512 half", v & 16'h60, 16'h40);
        check("R12", "half irq", 16'(irq), 16'h1);
        for (int i = 0; i < 512; i++) begin pulse_pacer; @(negedge clk); end
        bus_read(A_STAT, v); check("R9", "1024 full", v & 16'h40, 16'h0);
        pulse_pacer; @(negedge clk);
        bus_write(A_TRIG, 16'h0000);
        bad = 0;
        bus_read(A_DATA, v); if (v !== 16'd0) bad++;
        bus_read(A_STAT, v); check("R9", "not full after pop", v & 16'h40, 16'h40);
        for (int i = 1; i < 1024; i++) begin
            bus_read(A_DATA, v);
            if (v !== 16'(i)) bad++;
        end
        check("R9", "fifo order mismatches", 16'(bad), 16'h0);
        bus_read(A_STAT, v); check("R9", "overflow sample dropped", v & 16'h10, 16'h0);
        bus_write(A_INTC, 16'h0000);
        bus_write(A_ICLR, 16'h0);
    endtask

    task automatic t_dio;
        logic [15:0] v;
        bus_write(A_DATA, 16'hBEEF); check("R14", "dac_out", dac_out, 16'hBEEF);
        bus_write(A_DIO, 16'h5A5A);  check("R14", "dout", dout, 16'h5A5A);
        din = 16'h1357;
        bus_read(A_DIO, v); check("R14", "din", v, 16'h1357);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset;
        t_range;
        t_soft;
        t_ignored;
        t_scan;
        t_intsrc;
        t_flush;
        t_fill;
        t_dio;
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog expired: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule